// File: doc/BRIEF.md
# Quarter-Rate Complex Downmixer

This block turns a real, subsampled intermediate-frequency stream into complex baseband. It is built for a sample clock at which the wanted signal has aliased to exactly one quarter of the sample rate. For a 4 MHz sample clock, that IF is 1 MHz. Each accepted 8-bit two's-complement sample is multiplied by a cosine term to form the in-phase lane and by a negated sine term to form the quadrature lane. The carrier then sits at DC.

At a quarter-rate IF both terms take only the values +1, 0 and -1. Mixing therefore reduces to passing, negating or zeroing the sample, and no multiplier or lookup table is needed. A four-state phase sequencer steps once per accepted sample and selects the term applied to each lane.

The two lanes are registered together with one valid strobe. They are meant to feed separate lowpass decimating filters, which remove the image at twice the carrier.

The sequencer states are PH_0, PH_90, PH_180 and PH_270. The transition ADVANCE moves PH_0 to PH_90, PH_90 to PH_180, PH_180 to PH_270, and PH_270 back to PH_0 (the WRAP transition). ADVANCE is taken on every accepted sample. The transition HOLD keeps the current state on any cycle with no accepted sample. RESET forces PH_0 from any state.

Top module: `fs4_downmix`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces the sequencer to PH_0 and clears `out_valid`. The first sample accepted after reset is mixed with phase PH_0.
- R2: The phase advances only on a cycle where a sample is accepted (`in_valid` and `in_ready` both high). Idle cycles leave the phase unchanged.
- R3: In PH_0 the outputs are I = +x and Q = 0.
- R4: In PH_90 the outputs are I = 0 and Q = -x.
- R5: In PH_180 the outputs are I = -x and Q = 0.
- R6: In PH_270 the outputs are I = 0 and Q = +x.
- R7: Outputs are 9-bit two's complement, sign-extended from the input. Negating -128 gives +128 without overflow, and every output lies in [-128, +128].
- R8: A sample accepted at one rising edge appears on `out_i`/`out_q` with `out_valid` high after that same edge. `out_valid` stays high for exactly one cycle per accepted sample.
- R9: On cycles with no accepted sample, `out_i` and `out_q` hold their previous values.
- R10: `in_ready` is low while `rst` is high and high otherwise.
- R11: After PH_270 the next accepted sample uses PH_0, so the pattern repeats every four samples.
- R12: On every valid output, at least one of I and Q is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_sample | input | 8 | Signed IF sample |
| out_valid | output | 1 | I/Q pair valid strobe |
| out_i | output | 9 | Signed in-phase result |
| out_q | output | 9 | Signed quadrature result |

## Verification
The assertions take `rst` to be a clean synchronous level. They also take `in_valid` and `in_sample` to be driven to known values at every sampled edge outside reset. The bench meets this by changing inputs only on falling edges and by holding `in_valid` low whenever no sample is offered. Stimulus includes back-to-back samples through two full phase cycles, idle gaps between samples, the extreme codes -128 and +127, and a reset applied mid-cycle.

// File: rtl/fs4_mix_pkg.sv
package fs4_mix_pkg;
    typedef enum logic [1:0] {
        PH_0   = 2'd0,
        PH_90  = 2'd1,
        PH_180 = 2'd2,
        PH_270 = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        T_ZERO = 2'd0,
        T_POS  = 2'd1,
        T_NEG  = 2'd2
    } term_e;

    localparam int NUM_LANES = 2;
endpackage

// File: rtl/fs4_phase_seq.sv
module fs4_phase_seq
    import fs4_mix_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    output phase_e phase,
    output term_e  term_i,
    output term_e  term_q
);
    phase_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_0;
        else     state_q <= state_d;
    end

    // next state: ADVANCE / WRAP / HOLD
    always_comb begin
        state_d = state_q;
        if (advance) begin
            unique case (state_q)
                PH_0:    state_d = PH_90;
                PH_90:   state_d = PH_180;
                PH_180:  state_d = PH_270;
                PH_270:  state_d = PH_0;
                default: state_d = PH_0;
            endcase
        end
    end

    // outputs: cosine term on I, negated sine term on Q
    always_comb begin
        term_i = T_ZERO;
        term_q = T_ZERO;
        unique case (state_q)
            PH_0:    begin term_i = T_POS;  term_q = T_ZERO; end
            PH_90:   begin term_i = T_ZERO; term_q = T_NEG;  end
            PH_180:  begin term_i = T_NEG;  term_q = T_ZERO; end
            PH_270:  begin term_i = T_ZERO; term_q = T_POS;  end
            default: begin term_i = T_ZERO; term_q = T_ZERO; end
        endcase
    end

    assign phase = state_q;

    assert_reset_phase_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> state_q == PH_0);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(state_q));
    assert_wrap_R11: assert property (@(posedge clk) disable iff (rst)
        (advance && state_q == PH_270) |=> state_q == PH_0);
endmodule

// File: rtl/fs4_lane_mix.sv
module fs4_lane_mix
    import fs4_mix_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + 1
) (
    input  logic signed [IN_W-1:0]  sample,
    input  term_e                   term,
    output logic signed [OUT_W-1:0] mixed
);
    logic signed [OUT_W-1:0] ext;

    always_comb begin
        ext = OUT_W'(sample);
        unique case (term)
            T_POS:   mixed = ext;
            T_NEG:   mixed = -ext;
            default: mixed = '0;
        endcase
    end
endmodule

// File: rtl/fs4_iq_reg.sv
module fs4_iq_reg #(
    parameter int OUT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic signed [OUT_W-1:0] i_d,
    input  logic signed [OUT_W-1:0] q_d,
    output logic                    valid,
    output logic signed [OUT_W-1:0] i_q,
    output logic signed [OUT_W-1:0] q_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            i_q   <= '0;
            q_q   <= '0;
        end else begin
            valid <= load;
            if (load) begin
                i_q <= i_d;
                q_q <= q_d;
            end
        end
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        load |=> valid);
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> !valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(i_q) && $stable(q_q)));
endmodule

// File: rtl/fs4_downmix.sv
module fs4_downmix
    import fs4_mix_pkg::*;
#(
    parameter int IN_W = 8,
    localparam int OUT_W = IN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_sample,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);
    localparam int MAG = 2 ** (IN_W - 1);

    logic   fire;
    phase_e phase;
    term_e  lane_term [NUM_LANES];
    logic signed [OUT_W-1:0] lane_val [NUM_LANES];

    assign in_ready = !rst;
    assign fire     = in_valid && in_ready;

    fs4_phase_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .advance (fire),
        .phase   (phase),
        .term_i  (lane_term[0]),
        .term_q  (lane_term[1])
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        fs4_lane_mix #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mix (
            .sample (in_sample),
            .term   (lane_term[g]),
            .mixed  (lane_val[g])
        );
    end

    fs4_iq_reg #(.OUT_W(OUT_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (fire),
        .i_d   (lane_val[0]),
        .q_d   (lane_val[1]),
        .valid (out_valid),
        .i_q   (out_i),
        .q_q   (out_q)
    );

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_i) >= -MAG && int'(out_i) <= MAG &&
                       int'(out_q) >= -MAG && int'(out_q) <= MAG));
    assert_one_lane_zero_R12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_i == '0 || out_q == '0));
endmodule

// File: tb/tb_fs4_downmix.sv
module tb_fs4_downmix;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [7:0] in_sample = '0;
    logic out_valid;
    logic signed [8:0] out_i, out_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fs4_downmix dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // sample, expected I, expected Q; phases PH_0..PH_270 repeating from reset
    localparam int NV = 12;
    localparam int VS [NV] = '{  10,  20,  30,  40, -128, -128, -128, -128, 127,  127, -1, 5};
    localparam int VI [NV] = '{  10,   0, -30,   0, -128,    0,  128,    0, 127,    0,  1, 0};
    localparam int VQ [NV] = '{   0, -20,   0,  40,    0,  128,    0, -128,   0, -127,  0, 5};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_one(input int s, input int ei, input int eq, input string req);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 8'(s);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " I"}, int'(out_i), ei);
        chk({req, " Q"}, int'(out_q), eq);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 ready low in reset", int'(in_ready), 0);
        chk("R1 valid low in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 ready high", int'(in_ready), 1);
        chk("R1 valid after reset", int'(out_valid), 0);

        // back-to-back table walk: R3 R4 R5 R6 R7 R8 R11
        for (int k = 0; k <= NV; k++) begin
            if (k > 0) begin
                chk("R8 valid back-to-back", int'(out_valid), 1);
                chk("R3-6 table I (R7)", int'(out_i), VI[k-1]);
                chk("R3-6 table Q (R7)", int'(out_q), VQ[k-1]);
            end
            if (k < NV) begin
                in_valid  = 1'b1;
                in_sample = 8'(VS[k]);
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // idle: R8 single strobe, R9 hold, R2 no advance
        chk("R8 strobe drops", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        chk("R9 hold I", int'(out_i), 0);
        chk("R9 hold Q", int'(out_q), 5);
        // 12 samples done -> PH_0 again (R11, R2)
        send_one(7, 7, 0, "R2 R11 phase after idle");
        repeat (2) @(negedge clk);
        send_one(-9, 0, 9, "R4 R2 gap sample");
        send_one(-128, 128, 0, "R5 R7 negate min");

        // mid-cycle reset (R1 R10)
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_sample = 8'sd50;
        @(negedge clk);
        chk("R10 ready low mid reset", int'(in_ready), 0);
        chk("R1 valid cleared", int'(out_valid), 0);
        in_valid = 1'b0;
        rst = 1'b0;
        send_one(9, 9, 0, "R1 R3 first after reset");
        send_one(100, 0, -100, "R4 second after reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule